// File: doc/BRIEF.md
# Adapter Control and Status Register

This block is an 8-bit control and status register that sits between a simple host register port and two neighbours: a LAN coprocessor and a line encoder. The host uses it to move a 16K window across a 64K packet buffer, to pass the coprocessor's interrupt onto the host bus, and to put the encoder into loopback. The window select is applied to a 14-bit window offset to form the full 16-bit buffer address. The host can also read the live coprocessor interrupt level.

The block also produces the channel-attention strobe to the coprocessor. A host write with the attention bit set starts a pulse. A small state machine with two states, `CA_IDLE` and `CA_HOLD`, then holds the pulse for a minimum time and ends it by itself. The coprocessor acts on the falling edge of this strobe, so the strobe is held for the shortest count of clock cycles that covers 500 ns.

The state machine moves from `CA_IDLE` to `CA_HOLD` on a write with bit 7 set, and loads its down-counter at that point. While in `CA_HOLD`, another write with bit 7 set reloads the counter and the machine stays in `CA_HOLD`. When the counter reaches zero with no new request, the machine moves from `CA_HOLD` back to `CA_IDLE`.

Top module: `adapter_csr`

## Requirements
- R1: Bits 1:0 hold a bank select, where 00 means bank 0, 01 bank 1, 10 bank 2 and 11 bank 3. `buf_addr` always equals {bank select, `win_offset`[13:0]}.
- R2: After reset, with `cop_irq` low, `rd_data` reads 0x00 and bank 0 is mapped. `chan_attn`, `loopback` and `host_irq` are all low.
- R3: Bit 3 is interrupt enable. `host_irq` is high exactly when bit 3 is 1 and `cop_irq` is high.
- R4: Bit 4 is read-only. It shows the present level of `cop_irq` in the same cycle, with no latching.
- R5: Bit 6 is loopback. It is written by the host, read back, and drives `loopback` from the cycle after the write.
- R6: A write with bit 7 at 1 raises `chan_attn` in the next cycle. `chan_attn` then stays high for exactly CA_CYCLES = ceil(CA_MIN_PS / CLK_PERIOD_PS) cycles, which is 100 with the defaults, and falls by itself. Bit 7 reads the same level as `chan_attn`.
- R7: A write with bit 7 at 0 during an active pulse does not shorten it. The other fields in that write still take effect.
- R8: A write with bit 7 at 1 during an active pulse restarts the count, so `chan_attn` stays high for CA_CYCLES cycles after that write.
- R9: Bits 5 and 2 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current register value, combinational |
| cop_irq | input | 1 | Coprocessor interrupt line |
| host_irq | output | 1 | Gated interrupt to the host bus |
| loopback | output | 1 | Encoder loopback control |
| chan_attn | output | 1 | Channel-attention strobe to the coprocessor |
| win_offset | input | 14 | Offset within the 16K host window |
| buf_addr | output | 16 | Full 64K buffer address |

## Verification
The bench measures the exact length of the attention pulse in cycles.

- An off-by-one counter shows up as a width of 99 or 101 instead of 100.
- A design that clears the pulse on a zero write shows up as a short pulse.
- A design that does not reload its counter on a repeated write shows up as a pulse that is too short after the restart.

The bench toggles `cop_irq` inside a single cycle while interrupt enable is off. A latched status bit or an ungated `host_irq` fails this check. Writes that set only the reserved bits, writes of all ones, and extreme window offsets expose three faults: masking errors, bank bits swapped in the address, and bank bits placed in the wrong field.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;
    typedef enum logic {
        CA_IDLE = 1'b0,
        CA_HOLD = 1'b1
    } ca_state_t;

    localparam int BIT_CA   = 7;
    localparam int BIT_LBK  = 6;
    localparam int BIT_IRQ  = 4;
    localparam int BIT_IEN  = 3;
    localparam logic [7:0] WR_MASK = 8'h4B;
endpackage

// File: rtl/ca_strobe_fsm.sv
`timescale 1ns/1ps
module ca_strobe_fsm
    import csr_pkg::*;
#(
    parameter int CA_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic ca_o
);
    localparam int CNT_W = $clog2(CA_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CA_CYCLES - 1);
    localparam int RUN_W = CNT_W + 1;

    ca_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CA_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CA_IDLE: begin
                if (set_req) begin
                    state_d = CA_HOLD;
                    cnt_d   = LOAD;
                end
            end
            CA_HOLD: begin
                if (set_req) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = CA_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = CA_IDLE;
        endcase
    end

    always_comb begin
        ca_o = (state_q == CA_HOLD);
    end

    logic [RUN_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (!ca_o) begin
            hi_run <= '0;
        end else if (hi_run != {RUN_W{1'b1}}) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ca_o) |-> (hi_run >= RUN_W'(CA_CYCLES)));

    a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> ca_o);
endmodule

// File: rtl/bank_window.sv
`timescale 1ns/1ps
module bank_window #(
    parameter int BANK_W = 2,
    parameter int OFF_W  = 14
) (
    input  logic [BANK_W-1:0]       bank,
    input  logic [OFF_W-1:0]        offset,
    output logic [BANK_W+OFF_W-1:0] addr
);
    always_comb begin
        addr = {bank, offset};
    end
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate (
    input  logic irq_en,
    input  logic cop_irq,
    output logic host_irq,
    output logic irq_live
);
    always_comb begin
        host_irq = irq_en & cop_irq;
        irq_live = cop_irq;
    end
endmodule

// File: rtl/adapter_csr.sv
`timescale 1ns/1ps
module adapter_csr
    import csr_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int CA_MIN_PS     = 500000,
    parameter int BANK_W        = 2,
    parameter int OFF_W         = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_data,
    output logic [7:0]              rd_data,
    input  logic                    cop_irq,
    output logic                    host_irq,
    output logic                    loopback,
    output logic                    chan_attn,
    input  logic [OFF_W-1:0]        win_offset,
    output logic [BANK_W+OFF_W-1:0] buf_addr
);
    localparam int CA_CYCLES = (CA_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    logic [7:0] ctrl_q;
    logic       irq_live;
    logic       set_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data & WR_MASK;
        end
    end

    always_comb begin
        set_req = wr_en & wr_data[BIT_CA];
    end

    ca_strobe_fsm #(.CA_CYCLES(CA_CYCLES)) u_ca (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .ca_o    (chan_attn)
    );

    irq_gate u_irq (
        .irq_en   (ctrl_q[BIT_IEN]),
        .cop_irq  (cop_irq),
        .host_irq (host_irq),
        .irq_live (irq_live)
    );

    bank_window #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_win (
        .bank   (ctrl_q[BANK_W-1:0]),
        .offset (win_offset),
        .addr   (buf_addr)
    );

    always_comb begin
        rd_data          = ctrl_q & WR_MASK;
        rd_data[BIT_CA]  = chan_attn;
        rd_data[BIT_IRQ] = irq_live;
        loopback         = ctrl_q[BIT_LBK];
    end

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> cop_irq);
    a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> rd_data[BIT_IEN]);
    a_r1_addr_bank: assert property (@(posedge clk) disable iff (!rst_n)
        buf_addr[BANK_W+OFF_W-1:OFF_W] == rd_data[BANK_W-1:0]);
    a_r5_lbk_readback: assert property (@(posedge clk) disable iff (!rst_n)
        loopback == rd_data[BIT_LBK]);
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5] == 1'b0) && (rd_data[2] == 1'b0));
endmodule

// File: tb/tb_adapter_csr.sv
`timescale 1ns/1ps
module tb_adapter_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        cop_irq = 1'b0;
    logic        host_irq, loopback, chan_attn;
    logic [13:0] win_offset = '0;
    logic [15:0] buf_addr;

    int tests = 0;
    int fails = 0;

    localparam int EXP_CA = (500000 + 5000 - 1) / 5000;

    always #2.5 clk = ~clk;

    adapter_csr dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cop_irq(cop_irq), .host_irq(host_irq),
        .loopback(loopback), .chan_attn(chan_attn),
        .win_offset(win_offset), .buf_addr(buf_addr)
    );

    // {wdata, irq, offset, exp_rd, exp_hirq, exp_lbk, exp_addr}
    localparam int NV = 7;
    localparam logic [48:0] VEC [NV] = '{
        {8'h01, 1'b0, 14'h0000, 8'h01, 1'b0, 1'b0, 16'h4000},
        {8'h0A, 1'b1, 14'h3FFF, 8'h1A, 1'b1, 1'b0, 16'hBFFF},
        {8'h0B, 1'b0, 14'h1234, 8'h0B, 1'b0, 1'b0, 16'hD234},
        {8'h43, 1'b1, 14'h2AAA, 8'h53, 1'b0, 1'b1, 16'hEAAA},
        {8'h24, 1'b1, 14'h0001, 8'h10, 1'b0, 1'b0, 16'h0001},
        {8'h7F, 1'b1, 14'h0155, 8'h5B, 1'b1, 1'b1, 16'hC155},
        {8'h08, 1'b1, 14'h0000, 8'h18, 1'b1, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // starts a pulse, optionally injects a write at step inj_at, returns high width
    task automatic pulse_width(input int inj_at, input logic [7:0] inj, output int w);
        do_write(8'h80);
        w = 0;
        while (chan_attn && w < 1000) begin
            w++;
            if (w == inj_at) begin
                wr_en = 1'b1;
                wr_data = inj;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int w;
        win_offset = 14'h2000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 rd_data", 32'(rd_data), 32'h00);
        chk("R2 chan_attn", 32'(chan_attn), 0);
        chk("R2 loopback", 32'(loopback), 0);
        chk("R2 host_irq", 32'(host_irq), 0);
        chk("R2 bank0 addr", 32'(buf_addr), 32'h2000);

        for (int i = 0; i < NV; i++) begin
            cop_irq = VEC[i][40];
            win_offset = VEC[i][39:26];
            do_write(VEC[i][48:41]);
            #1;
            chk("R1 R3 R4 R9 rd_data", 32'(rd_data), 32'(VEC[i][25:18]));
            chk("R3 host_irq", 32'(host_irq), 32'(VEC[i][17]));
            chk("R5 loopback", 32'(loopback), 32'(VEC[i][16]));
            chk("R1 buf_addr", 32'(buf_addr), 32'(VEC[i][15:0]));
        end

        // R4 live, unlatched, inte off
        do_write(8'h00);
        cop_irq = 1'b1;
        #1;
        chk("R4 live high", 32'(rd_data[4]), 1);
        chk("R3 gated off", 32'(host_irq), 0);
        cop_irq = 1'b0;
        #1;
        chk("R4 not latched", 32'(rd_data[4]), 0);

        // R6 width
        pulse_width(0, 8'h00, w);
        chk("R6 pulse width", 32'(w), 32'(EXP_CA));
        chk("R6 auto release", 32'(chan_attn), 0);
        chk("R6 bit7 reads low", 32'(rd_data[7]), 0);

        // R6 bit7 reads high during pulse
        do_write(8'h80);
        chk("R6 bit7 reads high", 32'(rd_data[7]), 1);
        while (chan_attn) @(negedge clk);

        // R7 zero write ignored, other fields apply
        pulse_width(10, 8'h40, w);
        chk("R7 zero write ignored", 32'(w), 32'(EXP_CA));
        chk("R7 loopback applied", 32'(loopback), 1);

        // R8 restart
        pulse_width(10, 8'h80, w);
        chk("R8 restart width", 32'(w), 32'(EXP_CA + 10));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule